// File: doc/BRIEF.md
# Cellular-Automaton Subkey Generator

This block produces round subkeys for a Feistel-style block cipher from a 128-bit key. The key is held as two 64-bit halves. On every step, each half is rotated left by nine places and then updated once by a second-order, reversible one-dimensional cellular automaton that uses rule 45. In this second-order form, each new cell value is the rule output XORed with the cell's value from the step before. The two halves that result form the next pair of subkeys. They also become the key state for the step that follows.

A fixed 64-bit constant, set by a parameter, seeds the previous-generation register of both automata whenever a key is loaded. This lets the first step depend on a known prior generation. The cipher's round logic advances the generator one step per round, in parallel with its data path. It reads the subkey pair in the cycle in which the valid flag is high. A small counter reports how many steps have been taken since the last key load.

Top module: `kgen_ca_subkey`

## Requirements
- R1: While reset is high, and in the first cycle after it, both subkey outputs are zero, the valid flag is low and the step index is zero. Reset also places the seed constant in both previous-generation registers.
- R2: A load strobe captures key bits [127:64] as the left half and bits [63:0] as the right half. Both are visible on the outputs in the next cycle, with the valid flag low and the step index zero.
- R3: Before the automaton update, each half is rotated left by 9 bits: rotated bit i equals stored bit (i-9) mod 64.
- R4: With a the rotated half and p its previous generation, new bit i equals a[(i+1) mod 64] XOR (a[i] OR NOT a[(i-1) mod 64]) XOR p[i]. The neighbourhood wraps around the 64 cells.
- R5: After a step, the previous generation of each half becomes the rotated value that the step used. This makes the update invertible.
- R6: The halves produced by one step are the state that the next step starts from. Back-to-back steps chain with no gap.
- R7: The valid flag is high in exactly the cycle after each accepted step. It stays high across back-to-back steps and is low otherwise.
- R8: The step index rises by one for each accepted step and wraps modulo 2^IDX_W. A load clears it.
- R9: When load and step are strobed in the same cycle, the load takes effect and the step is ignored: there is no valid pulse and no index change.
- R10: With neither load nor step, the subkeys and the index hold their values.
- R11: After any load, the first step uses the parameter constant as the previous generation of both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Capture key_in as the new key state |
| key_in | input | 128 | Initial key, left half in the upper 64 bits |
| key_step | input | 1 | Advance the automaton by one step |
| subkey_l | output | 64 | Left subkey |
| subkey_r | output | 64 | Right subkey |
| subkey_vld | output | 1 | High for one cycle after each accepted step |
| step_idx | output | IDX_W | Steps taken since the last load |

## Verification
The embedded assertions check the following on every cycle:
- Load priority, key capture, holding when idle, and index counting.
- The valid pulse rule.
- Invertibility of each half: the old previous generation must be recoverable from the new state by applying the rule to the stored rotated value.

Only the bench's scenarios can confirm the actual subkey values. It does this with an independent model of the rotation, the wrapped rule-45 neighbourhood and the constant seed. This covers chaining over long runs, index wrap-around and the outcome of a step strobed together with a load.

// File: rtl/kgen_pkg.sv
package kgen_pkg;

    localparam int unsigned HALF_W  = 64;
    localparam int unsigned KEY_W   = 2 * HALF_W;
    localparam int unsigned ROT_AMT = 9;
    localparam logic [HALF_W-1:0] SEED_DEFAULT = 64'h9E3779B97F4A7C15;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [0:0] {
        HALF_RIGHT = 1'b0,
        HALF_LEFT  = 1'b1
    } half_sel_e;

    typedef struct packed {
        logic adv;
        logic load;
    } kgen_cmd_t;

    // Single rule-45 cell: left neighbour, centre, right neighbour.
    function automatic logic rule45_cell(input logic lft, input logic ctr, input logic rgt);
        return lft ^ (ctr | ~rgt);
    endfunction

    // Whole-word rule-45 image with cyclic wrap, used by checkers.
    function automatic half_t rule45_word(input half_t x);
        half_t y;
        for (int i = 0; i < int'(HALF_W); i++) begin
            y[i] = rule45_cell(x[(i + 1) % HALF_W], x[i], x[(i + HALF_W - 1) % HALF_W]);
        end
        return y;
    endfunction

endpackage

// File: rtl/kgen_ctrl.sv
module kgen_ctrl #(
    parameter int unsigned IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic                      step_i,
    output kgen_pkg::kgen_cmd_t       cmd_o,
    output logic                      valid_o,
    output logic [IDX_W-1:0]          idx_o
);
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    logic             valid_q;
    logic [IDX_W-1:0] idx_q;

    // Load has priority over a step issued in the same cycle.
    always_comb begin
        cmd_o.load = load_i;
        cmd_o.adv  = step_i & ~load_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= cmd_o.adv;
            if (cmd_o.load) begin
                idx_q <= '0;
            end else if (cmd_o.adv) begin
                idx_q <= idx_q + IDX_ONE;
            end
        end
    end

    assign valid_o = valid_q;
    assign idx_o   = idx_q;

    // R7: no valid pulse unless a step was accepted the cycle before
    p_valid_needs_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!step_i || load_i) |=> !valid_o);
    p_valid_after_step_r7: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> valid_o);
    // R8: load clears, accepted step increments
    p_idx_clear_r8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (idx_o == '0));
    p_idx_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (idx_o == $past(idx_o) + IDX_ONE));
    // R10: idle holds the index
    p_idx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(idx_o));

endmodule

// File: rtl/kgen_ca_half.sv
module kgen_ca_half #(
    parameter int unsigned          W    = kgen_pkg::HALF_W,
    parameter int unsigned          ROT  = kgen_pkg::ROT_AMT,
    parameter logic [W-1:0]         SEED = kgen_pkg::SEED_DEFAULT
) (
    input  logic                clk,
    input  logic                rst,
    input  kgen_pkg::kgen_cmd_t cmd_i,
    input  logic [W-1:0]        key_i,
    output logic [W-1:0]        state_o
);
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] rot_w;
    logic [W-1:0] nxt_w;

    // R3: circular left rotation ahead of the automaton
    assign rot_w = {cur_q[W-1-ROT:0], cur_q[W-1:W-ROT]};

    // R4: one rule-45 cell per bit, wrapped neighbourhood, second-order term
    for (genvar i = 0; i < int'(W); i++) begin : g_cell
        localparam int unsigned LI = (i + 1) % W;
        localparam int unsigned RI = (i + W - 1) % W;
        assign nxt_w[i] = kgen_pkg::rule45_cell(rot_w[LI], rot_w[i], rot_w[RI]) ^ prev_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            prev_q <= SEED;
        end else if (cmd_i.load) begin
            cur_q  <= key_i;
            prev_q <= SEED;
        end else if (cmd_i.adv) begin
            cur_q  <= nxt_w;
            prev_q <= rot_w;
        end
    end

    assign state_o = cur_q;

    // R11: a load seeds the previous generation with the constant
    p_seed_on_load_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_i.load |=> (prev_q == SEED));
    // R5: update is invertible -- old previous generation is recoverable
    p_reversible_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_i.adv |=> ((cur_q ^ kgen_pkg::rule45_word(prev_q)) == $past(prev_q)));
    // R10: idle holds both generations
    p_half_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.adv && !cmd_i.load) |=> ($stable(cur_q) && $stable(prev_q)));

endmodule

// File: rtl/kgen_ca_subkey.sv
module kgen_ca_subkey #(
    parameter logic [63:0] SEED  = kgen_pkg::SEED_DEFAULT,
    parameter int unsigned IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_load,
    input  logic [127:0]        key_in,
    input  logic                key_step,
    output logic [63:0]         subkey_l,
    output logic [63:0]         subkey_r,
    output logic                subkey_vld,
    output logic [IDX_W-1:0]    step_idx
);
    import kgen_pkg::*;

    localparam int unsigned NHALF = KEY_W / HALF_W;

    kgen_cmd_t cmd_w;
    half_t     half_st [NHALF];

    kgen_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_i  (key_load),
        .step_i  (key_step),
        .cmd_o   (cmd_w),
        .valid_o (subkey_vld),
        .idx_o   (step_idx)
    );

    for (genvar h = 0; h < int'(NHALF); h++) begin : g_half
        kgen_ca_half #(
            .W    (HALF_W),
            .ROT  (ROT_AMT),
            .SEED (SEED)
        ) u_half (
            .clk     (clk),
            .rst     (rst),
            .cmd_i   (cmd_w),
            .key_i   (key_in[h*HALF_W +: HALF_W]),
            .state_o (half_st[h])
        );
    end

    assign subkey_l = half_st[HALF_LEFT];
    assign subkey_r = half_st[HALF_RIGHT];

    // R2: load lands the key halves on the outputs
    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        key_load |=> ({subkey_l, subkey_r} == $past(key_in)));
    // R9: a step beside a load produces no valid pulse
    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (key_load && key_step) |=> !subkey_vld);
    // R10: outputs hold when idle
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!key_load && !key_step) |=> ($stable(subkey_l) && $stable(subkey_r)));

endmodule

// File: tb/kgen_ca_subkey_test.sv
module kgen_ca_subkey_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] SEED = 64'h9E3779B97F4A7C15;
    localparam int IW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           key_load = 1'b0;
    logic [127:0]   key_in = '0;
    logic           key_step = 1'b0;
    logic [63:0]    subkey_l, subkey_r;
    logic           subkey_vld;
    logic [IW-1:0]  step_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [63:0] m_l, m_r, m_pl, m_pr;
    logic [IW-1:0] m_idx;
    logic [135:0] exp_q [$];

    kgen_ca_subkey #(.SEED(SEED), .IDX_W(IW)) uut (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .key_step(key_step), .subkey_l(subkey_l), .subkey_r(subkey_r),
        .subkey_vld(subkey_vld), .step_idx(step_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rot9(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[i] = x[(i + 55) % 64];
        return y;
    endfunction

    function automatic logic [63:0] ca45(input logic [63:0] a, input logic [63:0] p);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) begin
            logic lf, ct, rt;
            lf = a[(i + 1) % 64];
            ct = a[i];
            rt = a[(i + 63) % 64];
            y[i] = lf ^ (ct | ~rt) ^ p[i];
        end
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic [63:0] al, ar;
        al = rot9(m_l);
        ar = rot9(m_r);
        m_l = ca45(al, m_pl);
        m_r = ca45(ar, m_pr);
        m_pl = al;
        m_pr = ar;
        m_idx = m_idx + 1'b1;
        exp_q.push_back({m_l, m_r, m_idx});
    endtask

    task automatic do_load(input logic [127:0] k, input bit with_step);
        @(negedge clk);
        key_load = 1'b1;
        key_in = k;
        key_step = with_step;
        m_l = k[127:64]; m_r = k[63:0]; m_pl = SEED; m_pr = SEED; m_idx = '0;
        @(negedge clk);
        key_load = 1'b0;
        key_step = 1'b0;
        check({subkey_l, subkey_r} == k, "R2 key capture", {subkey_l, subkey_r}, k);
        check(step_idx == '0 && subkey_vld == 1'b0, "R2 R9 idx/valid after load",
              {step_idx, subkey_vld}, 0);
    endtask

    task automatic do_steps(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            key_step = 1'b1;
            model_step();
        end
        @(negedge clk);
        key_step = 1'b0;
    endtask

    // monitor: pops an expected item for every valid cycle
    always @(posedge clk) begin
        #2;
        if (!rst && subkey_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected valid", {127'b0, subkey_vld}, 0);
            end else begin
                logic [135:0] e;
                e = exp_q.pop_front();
                check({subkey_l, subkey_r} == e[135:8], "R4 subkeys (R3 R5 R6 R11)",
                      {subkey_l, subkey_r}, e[135:8]);
                check(step_idx == e[7:0], "R8 step index", {120'b0, step_idx}, {120'b0, e[7:0]});
            end
        end
    end

    initial begin
        fork
            begin
                while (cycles < 100000) begin
                    @(posedge clk);
                    cycles++;
                end
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        m_l = '0; m_r = '0; m_pl = SEED; m_pr = SEED; m_idx = '0;
        repeat (3) @(negedge clk);
        check({subkey_l, subkey_r} == '0, "R1 reset subkeys", {subkey_l, subkey_r}, 0);
        check(subkey_vld == 1'b0 && step_idx == '0, "R1 reset valid/idx", {subkey_vld, step_idx}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({subkey_l, subkey_r} == '0 && !subkey_vld, "R1 first cycle after reset",
              {subkey_l, subkey_r}, 0);

        // step straight from reset: seed constant as previous generation
        do_steps(1);

        do_load(128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0);
        do_steps(5);                     // R6 R7 back-to-back chaining
        check(subkey_vld == 1'b1, "R7 valid after last step", subkey_vld, 1);
        @(negedge clk);
        check(subkey_vld == 1'b0, "R7 valid drops when idle", subkey_vld, 0);

        // R10: hold while idle
        repeat (4) @(negedge clk);
        check({subkey_l, subkey_r} == {m_l, m_r}, "R10 outputs hold", {subkey_l, subkey_r}, {m_l, m_r});
        check(step_idx == m_idx, "R10 index holds", step_idx, m_idx);

        // R9: load and step together
        do_load(128'h8000000000000001_0000000000000000, 1'b1);
        @(negedge clk);
        check(step_idx == '0 && !subkey_vld, "R9 step ignored under load", {step_idx, subkey_vld}, 0);

        // single steps separated by gaps
        for (int g = 0; g < 3; g++) begin
            do_steps(1);
            @(negedge clk);
        end

        // R8 wrap: 256 steps from a fresh load
        do_load({128{1'b1}}, 1'b0);
        do_steps(256);
        @(negedge clk);
        check(step_idx == '0, "R8 index wraps to zero", step_idx, 0);
        check(exp_q.size() == 0, "R7 every step produced valid", exp_q.size(), 0);

        // reload clears index mid-run
        do_load(128'hDEADBEEF00000000_00000000CAFEF00D, 1'b0);
        do_steps(2);
        @(negedge clk);
        check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule